// File: doc/BRIEF.md
# Flag Offset Programming Unit

This unit keeps the two threshold offsets that a FIFO's partial flags are compared against: one measured from the empty boundary (almost-empty) and one measured from the full boundary (almost-full). It drives both values to the flag comparator continuously. The FIFO storage and the pointer logic are outside the unit.

A master reset loads both offsets with a default. The level of the load control during that reset picks one of two defaults. The same level also fixes how the offsets may be reprogrammed until the next master reset: either one bit per clock through a serial input, or one whole word per access through a parallel write bus. Readback always uses the parallel output bus, whatever the loading method. A partial reset restarts the access sequencing. It keeps the offsets and the chosen method.

Top module: `flag_offset_prog`

## Requirements
- R1: A cycle with `mrst` high loads both offsets with 127 when `ldEn` is 0, or with 1023 when `ldEn` is 1. The new values appear on `aeOffset` and `afOffset` after that clock edge.
- R2: The `ldEn` level sampled during `mrst` selects the programming method: 0 selects parallel, 1 selects serial. The method holds until the next master reset.
- R3: In serial mode, each cycle with `ldEn` and `serEn` high shifts `serIn` into bit 0 of the target offset, with the existing bits moving one place toward the MSB (MSB-first loading). The first OFFSET_W shifts go to almost-empty, the next OFFSET_W go to almost-full, and the sequence then returns to almost-empty.
- R4: In parallel mode, each cycle with `ldEn` and `wrEn` high writes `wrData[OFFSET_W-1:0]` into an offset. Successive writes alternate, starting with almost-empty, then almost-full, then almost-empty again.
- R5: Each cycle with `ldEn` and `rdEn` high places an offset, zero-extended, on `rdData` one clock later. Successive reads alternate, starting with almost-empty, then almost-full. This works in both modes. Between reads `rdData` holds its value.
- R6: `prst` leaves both offsets and the programming method unchanged. It returns the write, shift and read sequencing to almost-empty.
- R7: In serial mode, parallel writes have no effect. In parallel mode, serial shifts have no effect.
- R8: When `ldEn` is low, `wrEn`, `serEn` and `rdEn` change neither offset and do not change `rdData`.
- R9: `mrst` returns all sequencing to almost-empty and clears `rdData` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| ldEn | input | 1 | Load control; sampled during `mrst` to choose default and method |
| serEn | input | 1 | Serial shift enable |
| serIn | input | 1 | Serial data bit |
| wrEn | input | 1 | Parallel write enable |
| wrData | input | DATA_W | Parallel write data |
| rdEn | input | 1 | Parallel readback enable |
| rdData | output | DATA_W | Readback data, registered |
| aeOffset | output | OFFSET_W | Almost-empty offset |
| afOffset | output | OFFSET_W | Almost-full offset |

## Verification
The bench uses both reset levels of the load control and confirms the default value and the method each level selects. In parallel mode it sweeps sixteen pairs of arithmetically spread words through write and readback. This separates the two registers and exposes a stuck or swapped step in the alternation. In serial mode it first stops part-way through a word, which shows the bit order and the position of each shift. It then loads full-length pairs, which show the handover from almost-empty to almost-full. The bench also drives enables without the load control, drives the method that was not selected, and applies a partial reset mid-sequence. After each of these it confirms at the outputs that nothing changed except the sequencing.

// File: rtl/flag_ofs_pkg.sv
package flag_ofs_pkg;

  typedef struct packed {
    logic loadDef;   // apply reset default
    logic defLarge;  // default choice
    logic shiftAe;   // shift serial bit into almost-empty
    logic shiftAf;   // shift serial bit into almost-full
    logic wrAe;      // parallel write almost-empty
    logic wrAf;      // parallel write almost-full
    logic rdAe;      // read almost-empty
    logic rdAf;      // read almost-full
    logic clrRd;     // clear readback register
  } ofsStrobe_t;

endpackage

// File: rtl/flag_ofs_ctrl.sv
module flag_ofs_ctrl
  import flag_ofs_pkg::*;
#(
  parameter int OFFSET_W = 12
) (
  input  logic       clk,
  input  logic       mrst,
  input  logic       prst,
  input  logic       ldEn,
  input  logic       serEn,
  input  logic       wrEn,
  input  logic       rdEn,
  output ofsStrobe_t strb
);

  localparam int CNT_W = $clog2(2 * OFFSET_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(2 * OFFSET_W - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OFFSET_W);

  logic             serialMode;
  logic             wrSel;      // 0: almost-empty next, 1: almost-full next
  logic             rdSel;
  logic [CNT_W-1:0] bitCnt;
  logic             armed = 1'b0;

  logic opOk;
  logic shiftOk;
  logic writeOk;
  logic readOk;

  always_comb begin
    opOk    = !mrst && !prst && ldEn;
    shiftOk = opOk && serEn && serialMode;
    writeOk = opOk && wrEn && !serialMode;
    readOk  = opOk && rdEn;

    strb          = '0;
    strb.loadDef  = mrst;
    strb.defLarge = ldEn;
    strb.clrRd    = mrst;
    strb.shiftAe  = shiftOk && (bitCnt < CNT_HALF);
    strb.shiftAf  = shiftOk && (bitCnt >= CNT_HALF);
    strb.wrAe     = writeOk && !wrSel;
    strb.wrAf     = writeOk && wrSel;
    strb.rdAe     = readOk && !rdSel;
    strb.rdAf     = readOk && rdSel;
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      serialMode <= ldEn;
      wrSel      <= 1'b0;
      rdSel      <= 1'b0;
      bitCnt     <= '0;
      armed      <= 1'b1;
    end else if (prst) begin
      wrSel  <= 1'b0;
      rdSel  <= 1'b0;
      bitCnt <= '0;
    end else begin
      if (writeOk) wrSel <= ~wrSel;
      if (readOk)  rdSel <= ~rdSel;
      if (shiftOk) bitCnt <= (bitCnt == CNT_LAST) ? '0 : bitCnt + 1'b1;
    end
  end

  // R2/R6: method only changes under master reset
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!armed)
    !mrst |=> $stable(serialMode));

  // R6: partial reset restarts every sequence
  p_seq_restart_r6: assert property (@(posedge clk) disable iff (!armed)
    (prst && !mrst) |=> (!wrSel && !rdSel && bitCnt == '0));

  // R3: serial bit counter never leaves its range
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!armed)
    bitCnt <= CNT_LAST);

  // R8: without load control the sequencing does not advance
  p_no_ld_hold_r8: assert property (@(posedge clk) disable iff (!armed)
    (!ldEn && !mrst && !prst) |=> ($stable(wrSel) && $stable(rdSel) && $stable(bitCnt)));

endmodule

// File: rtl/flag_ofs_datapath.sv
module flag_ofs_datapath
  import flag_ofs_pkg::*;
#(
  parameter int OFFSET_W  = 12,
  parameter int DATA_W    = 12,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023
) (
  input  logic                clk,
  input  ofsStrobe_t          strb,
  input  logic                serIn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [OFFSET_W-1:0] aeReg,
  output logic [OFFSET_W-1:0] afReg
);

  localparam logic [OFFSET_W-1:0] SMALL_V = OFFSET_W'(DEF_SMALL);
  localparam logic [OFFSET_W-1:0] LARGE_V = OFFSET_W'(DEF_LARGE);

  logic [OFFSET_W-1:0] wrWord;
  logic [OFFSET_W-1:0] defWord;
  logic [DATA_W-1:0]   aeWide;
  logic [DATA_W-1:0]   afWide;
  logic                armed = 1'b0;

  generate
    if (DATA_W > OFFSET_W) begin : g_pad
      assign wrWord = wrData[OFFSET_W-1:0];
      assign aeWide = {{(DATA_W-OFFSET_W){1'b0}}, aeReg};
      assign afWide = {{(DATA_W-OFFSET_W){1'b0}}, afReg};
    end else begin : g_exact
      assign wrWord = wrData[OFFSET_W-1:0];
      assign aeWide = aeReg[DATA_W-1:0];
      assign afWide = afReg[DATA_W-1:0];
    end
  endgenerate

  assign defWord = strb.defLarge ? LARGE_V : SMALL_V;

  always_ff @(posedge clk) begin
    if (strb.loadDef) begin
      aeReg <= defWord;
      afReg <= defWord;
      armed <= 1'b1;
    end else begin
      if (strb.shiftAe)     aeReg <= {aeReg[OFFSET_W-2:0], serIn};
      else if (strb.wrAe)   aeReg <= wrWord;
      if (strb.shiftAf)     afReg <= {afReg[OFFSET_W-2:0], serIn};
      else if (strb.wrAf)   afReg <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clrRd)       rdData <= '0;
    else if (strb.rdAe)   rdData <= aeWide;
    else if (strb.rdAf)   rdData <= afWide;
  end

  // R7: at most one register update source per cycle
  p_one_source_r7: assert property (@(posedge clk) disable iff (!armed)
    $onehot0({strb.loadDef, strb.shiftAe, strb.shiftAf, strb.wrAe, strb.wrAf}));

  // R1: defaults follow the load control level at master reset
  p_default_r1: assert property (@(posedge clk)
    strb.loadDef |=> (aeReg == ($past(strb.defLarge) ? LARGE_V : SMALL_V)) && (afReg == aeReg));

  // R5: readback of almost-empty lands one clock later
  p_read_ae_r5: assert property (@(posedge clk) disable iff (!armed)
    (strb.rdAe && !strb.clrRd) |=> rdData == DATA_W'($past(aeReg)));

  // R4: almost-full holds when nothing targets it
  p_af_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    !(strb.loadDef || strb.shiftAf || strb.wrAf) |=> $stable(afReg));

endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import flag_ofs_pkg::*;
#(
  parameter int OFFSET_W  = 12,
  parameter int DATA_W    = 12,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023
) (
  input  logic                clk,
  input  logic                mrst,
  input  logic                prst,
  input  logic                ldEn,
  input  logic                serEn,
  input  logic                serIn,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdEn,
  output logic [DATA_W-1:0]   rdData,
  output logic [OFFSET_W-1:0] aeOffset,
  output logic [OFFSET_W-1:0] afOffset
);

  ofsStrobe_t strb;

  flag_ofs_ctrl #(.OFFSET_W(OFFSET_W)) ctrl_i (
    .clk   (clk),
    .mrst  (mrst),
    .prst  (prst),
    .ldEn  (ldEn),
    .serEn (serEn),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .strb  (strb)
  );

  flag_ofs_datapath #(
    .OFFSET_W (OFFSET_W),
    .DATA_W   (DATA_W),
    .DEF_SMALL(DEF_SMALL),
    .DEF_LARGE(DEF_LARGE)
  ) dp_i (
    .clk    (clk),
    .strb   (strb),
    .serIn  (serIn),
    .wrData (wrData),
    .rdData (rdData),
    .aeReg  (aeOffset),
    .afReg  (afOffset)
  );

endmodule

// File: tb/flag_offset_prog_tb.sv
module flag_offset_prog_tb_top;

  localparam int W = 12;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         mrst = 1'b0, prst = 1'b0, ldEn = 1'b0, serEn = 1'b0, serIn = 1'b0;
  logic         wrEn = 1'b0, rdEn = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [W-1:0] rdData, aeOffset, afOffset;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  flag_offset_prog dut_i (
    .clk(clk), .mrst(mrst), .prst(prst), .ldEn(ldEn), .serEn(serEn),
    .serIn(serIn), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .aeOffset(aeOffset), .afOffset(afOffset)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ldEn = 0; serEn = 0; wrEn = 0; rdEn = 0;
  endtask

  task automatic doMrst(input logic ld);
    mrst = 1; ldEn = ld; @(negedge clk); idle();
  endtask

  task automatic doPrst();
    prst = 1; @(negedge clk); idle();
  endtask

  task automatic parWrite(input logic [W-1:0] v, input logic withLd);
    ldEn = withLd; wrEn = 1; wrData = v; @(negedge clk); idle();
  endtask

  task automatic serShift(input logic [W-1:0] v, input int nbits, input logic withLd);
    for (int b = nbits - 1; b >= 0; b--) begin
      ldEn = withLd; serEn = 1; serIn = v[b]; @(negedge clk);
    end
    idle();
  endtask

  task automatic readOne(input logic withLd, output logic [W-1:0] v);
    ldEn = withLd; rdEn = 1; @(negedge clk); idle(); v = rdData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, a, b, keepAe, keepAf;
    @(negedge clk);
    // R1, R9: small default, parallel mode
    doMrst(1'b0);
    check("R1 ae default small", aeOffset, 12'd127);
    check("R1 af default small", afOffset, 12'd127);
    check("R9 rdData cleared", rdData, '0);
    readOne(1'b1, r); check("R5 read ae default", r, 12'd127);
    readOne(1'b1, r); check("R5 read af default", r, 12'd127);
    doMrst(1'b0);

    // R4, R5: parallel sweep
    for (int i = 0; i < 16; i++) begin
      a = W'((i * 257 + 3) & MASK);
      b = W'((4095 - i * 311) & MASK);
      parWrite(a, 1'b1);
      check("R4 ae after first write", aeOffset, a);
      parWrite(b, 1'b1);
      check("R4 ae kept after second write", aeOffset, a);
      check("R4 af after second write", afOffset, b);
      readOne(1'b1, r); check("R5 read ae", r, a);
      readOne(1'b1, r); check("R5 read af", r, b);
    end
    keepAe = aeOffset; keepAf = afOffset;

    // R2, R7: serial shifts ignored in parallel mode
    serShift(12'h5A5, W, 1'b1);
    check("R7 ae unchanged by shift in parallel mode", aeOffset, keepAe);
    check("R7 af unchanged by shift in parallel mode", afOffset, keepAf);

    // R8: enables without load control
    parWrite(12'h123, 1'b0);
    check("R8 ae unchanged by write without ldEn", aeOffset, keepAe);
    readOne(1'b1, r);                       // rdData now holds ae
    readOne(1'b0, r);
    check("R8 rdData held without ldEn", r, keepAe);
    readOne(1'b1, r);
    check("R8 read sequence did not advance", r, keepAf);

    // R6: partial reset restarts sequencing, keeps offsets and mode
    parWrite(12'h0F0, 1'b1);                // to ae
    doPrst();
    check("R6 ae kept by prst", aeOffset, 12'h0F0);
    check("R6 af kept by prst", afOffset, keepAf);
    parWrite(12'h777, 1'b1);
    check("R6 write after prst goes to ae", aeOffset, 12'h777);
    check("R6 af untouched after prst write", afOffset, keepAf);
    readOne(1'b1, r);
    doPrst();
    readOne(1'b1, r);
    check("R6 read after prst returns ae", r, 12'h777);
    serShift(12'hFFF, W, 1'b1);
    check("R6 mode kept parallel after prst", aeOffset, 12'h777);

    // R1, R2, R9: large default, serial mode
    doMrst(1'b1);
    check("R1 ae default large", aeOffset, 12'd1023);
    check("R1 af default large", afOffset, 12'd1023);
    check("R9 rdData cleared again", rdData, '0);
    parWrite(12'h321, 1'b1);
    check("R7 ae unchanged by write in serial mode", aeOffset, 12'd1023);
    check("R2 af unchanged by write in serial mode", afOffset, 12'd1023);

    // R3: partial shift shows bit order
    serShift(12'h00A, 4, 1'b1);
    check("R3 ae after 4 shifts", aeOffset, W'(((12'd1023 << 4) | 12'hA) & MASK));
    check("R3 af untouched during ae shifts", afOffset, 12'd1023);
    serShift(12'h05C, 8, 1'b1);
    check("R3 ae complete", aeOffset, 12'hA5C);
    serShift(12'h3C1, W, 1'b1);
    check("R3 af after handover", afOffset, 12'h3C1);
    check("R3 ae kept during af shifts", aeOffset, 12'hA5C);

    for (int i = 0; i < 8; i++) begin
      a = W'((i * 1021 + 7) & MASK);
      b = W'((i * 613 + 2048) & MASK);
      serShift(a, W, 1'b1);
      check("R3 ae wrap load", aeOffset, a);
      serShift(b, W, 1'b1);
      check("R3 af load", afOffset, b);
      readOne(1'b1, r); check("R5 serial-mode read ae", r, a);
      readOne(1'b1, r); check("R5 serial-mode read af", r, b);
    end
    keepAf = afOffset;

    // R8: serial shift without load control
    serShift(12'h000, W, 1'b0);
    check("R8 ae unchanged by serEn without ldEn", aeOffset, a);

    // R6: partial reset in the middle of a serial word
    serShift(12'h01F, 5, 1'b1);
    doPrst();
    serShift(12'hBEE, W, 1'b1);
    check("R6 serial restarts at ae", aeOffset, 12'hBEE);
    check("R6 af kept across serial prst", afOffset, keepAf);

    // R9: master reset restarts read sequence
    readOne(1'b1, r);
    doMrst(1'b0);
    readOne(1'b1, r);
    check("R9 read after mrst returns ae", r, 12'd127);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule